// File: doc/BRIEF.md
# Router Forwarding Decision Controller

This block sits in a router's output-port lookup stage and settles the fate of each packet: forward to an Ethernet MAC port, hand to the CPU port, or discard. Packet words (64-bit data plus an 8-bit control sideband) enter over a write/ready handshake and wait in a small FIFO. Preprocessing units report a single bundle of per-packet results: the parser flags, the header-check flags, the filter, route and ARP lookup outcomes, the recomputed TTL and checksum. When that bundle is valid and a packet is at the FIFO head, the block acknowledges it with a one-cycle read strobe and applies a fixed chain of checks.

Packets that pass every check have their header edited as they stream out. The metadata word gets a one-hot destination, and the MAC addresses, TTL and header checksum are replaced. Packets sent to the CPU, or arriving from it, have only the destination field rewritten. Dropped packets are drained from the FIFO without any output. The output stalls word by word whenever the downstream is not ready. Packets are never reordered, merged or split.

Top module: `rtr_fwd_ctrl`

## Requirements
- R1: When the packet came from the CPU, it leaves with destination field = `cpu_dest_oh` and every other bit unchanged, whatever the other flags say.
- R2: A packet not from the CPU whose destination MAC is neither ours nor broadcast is dropped: no output word, and the FIFO is drained.
- R3: An accepted packet whose ethertype is not IP goes to the CPU. The destination is the one-hot bit 2*`in_mac_port`+1. MAC ports sit on even bits and CPU ports on odd bits.
- R4: An accepted IP packet with a bad header checksum is dropped, even when it also hits the filter.
- R5: An IP packet with a good checksum that hits the destination filter goes to the CPU, regardless of TTL, version, options, route or ARP state.
- R6: With a good checksum and no filter hit, the packet goes to the CPU when any of these holds: version not 4, options present, TTL not good, route miss or ARP miss.
- R7: A packet passing every check leaves with these fields set: destination = `route_dest_oh`; destination MAC = `arp_mac`; source MAC = the MAC of the lowest even set bit of `route_dest_oh` divided by two, taken from `port_macs` slot i at bits [48i+47:48i]; TTL = `new_ttl`; checksum = `new_csum`. All other bits are unchanged.
- R8: The word layout is fixed. Word 0 is metadata (ctrl 0xFF), with the destination field at data bits [48+2*NUM_MAC-1:48]. Word 1 holds the destination MAC in [63:16] and the source MAC high bits in [15:0]. Word 2 holds the source MAC low bits in [63:32]. Word 3 holds the TTL in [15:8]. Word 4 holds the checksum in [63:48]. Body words carry ctrl 0x00, and any other ctrl value marks the last word. Control values pass through unchanged.
- R9: Packets leave in arrival order and whole. The next packet's decision waits until the previous packet's last word has been handled.
- R10: While `out_rdy` is low, no word is written and the word on offer holds. `in_rdy` falls when the FIFO is full, and no word is lost.
- R11: `info_rd` pulses for exactly one cycle per packet. It only pulses when `info_vld` is high and a word is buffered.
- R12: After reset, `out_wr` and `info_rd` are low and `in_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 64 | Incoming packet word |
| in_ctrl | input | 8 | Incoming control sideband |
| in_wr | input | 1 | Incoming word valid |
| in_rdy | output | 1 | Block can take a word |
| out_data | output | 64 | Outgoing (edited) packet word |
| out_ctrl | output | 8 | Outgoing control sideband |
| out_wr | output | 1 | Outgoing word written this cycle |
| out_rdy | input | 1 | Downstream can take a word |
| info_vld | input | 1 | Result bundle for head packet valid |
| info_rd | output | 1 | One-cycle acknowledge of the bundle |
| src_is_cpu | input | 1 | Packet arrived from a CPU queue |
| cpu_dest_oh | input | 2*NUM_MAC | Destination chosen by the CPU |
| in_mac_port | input | clog2(NUM_MAC) | Index of the input MAC port |
| dmac_is_ours | input | 1 | Destination MAC equals port address |
| dmac_is_bcast | input | 1 | Destination MAC is broadcast |
| etype_is_ip | input | 1 | Ethertype is IP |
| ip_ver_ok | input | 1 | IP version equals 4 |
| ip_csum_ok | input | 1 | Header checksum correct |
| ip_has_opts | input | 1 | IP options present |
| ip_ttl_ok | input | 1 | TTL greater than 1 |
| new_ttl | input | 8 | Decremented TTL |
| new_csum | input | 16 | Updated header checksum |
| filt_hit | input | 1 | Destination filter table hit |
| route_hit | input | 1 | Routing table hit |
| route_dest_oh | input | 2*NUM_MAC | Route output port, one-hot |
| arp_hit | input | 1 | ARP table hit |
| arp_mac | input | 48 | Next-hop MAC |
| port_macs | input | 48*NUM_MAC | MAC address of each port |

## Verification
Each branch of the check chain is tried with flag sets chosen to tell apart which check fired first. A CPU-sourced packet carries flags that would otherwise cause a drop. A bad checksum is paired with a filter hit, and a filter hit with a bad TTL. Each of the five exception causes is raised alone. Forwarding is tried with two route ports and two input ports, which shows that the source MAC is chosen from the route and not from the input. A drop packet followed at once by a CPU packet shows packet boundaries are kept. A long forwarded packet held against a full FIFO and a toggling `out_rdy` shows that stalls neither lose nor alter words.

// File: rtl/rtr_fwd_pkg.sv
package rtr_fwd_pkg;
    localparam int DATA_W = 64;
    localparam int CTRL_W = 8;
    localparam int MAC_W  = 48;
    localparam int DEST_LSB = 48;
    localparam logic [CTRL_W-1:0] CTRL_META = 8'hFF;
    localparam logic [CTRL_W-1:0] CTRL_BODY = 8'h00;

    typedef enum logic [1:0] {ACT_DROP, ACT_CPU, ACT_PASS, ACT_FWD} act_e;
    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_DROP} st_e;
endpackage

// File: rtl/rtr_fwd_fifo.sv
module rtr_fwd_fifo #(
    parameter int WIDTH = 72,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] din,
    input  logic             rd,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fptr_t;

    fptr_t f_d, f_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic push, pop;

    assign empty = (f_q.cnt == '0);
    assign full  = (f_q.cnt == (AW+1)'(DEPTH));
    assign push  = wr && !full;
    assign pop   = rd && !empty;
    assign dout  = mem[f_q.rp];

    always_comb begin
        f_d = f_q;
        if (push) f_d.wp = f_q.wp + 1'b1;
        if (pop)  f_d.rp = f_q.rp + 1'b1;
        if (push && !pop)      f_d.cnt = f_q.cnt + 1'b1;
        else if (pop && !push) f_d.cnt = f_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push) mem[f_q.wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !full);
endmodule

// File: rtl/rtr_fwd_verdict.sv
module rtr_fwd_verdict
    import rtr_fwd_pkg::*;
#(
    parameter int NUM_MAC = 4,
    localparam int OH_W  = 2 * NUM_MAC,
    localparam int IDX_W = (NUM_MAC > 1) ? $clog2(NUM_MAC) : 1
) (
    input  logic             src_is_cpu,
    input  logic [OH_W-1:0]  cpu_dest_oh,
    input  logic [IDX_W-1:0] in_mac_port,
    input  logic             dmac_is_ours,
    input  logic             dmac_is_bcast,
    input  logic             etype_is_ip,
    input  logic             ip_ver_ok,
    input  logic             ip_csum_ok,
    input  logic             ip_has_opts,
    input  logic             ip_ttl_ok,
    input  logic             filt_hit,
    input  logic             route_hit,
    input  logic [OH_W-1:0]  route_dest_oh,
    input  logic             arp_hit,
    output act_e             act,
    output logic [OH_W-1:0]  dest_oh,
    output logic [IDX_W-1:0] mac_idx
);
    logic [OH_W-1:0] to_cpu_oh;

    always_comb begin
        to_cpu_oh = '0;
        to_cpu_oh[2*int'(in_mac_port)+1] = 1'b1;
    end

    // lowest even set bit of the route selects the source MAC slot
    always_comb begin
        mac_idx = '0;
        for (int i = NUM_MAC - 1; i >= 0; i--) begin
            if (route_dest_oh[2*i]) mac_idx = IDX_W'(i);
        end
    end

    always_comb begin
        act     = ACT_FWD;
        dest_oh = route_dest_oh;
        if (src_is_cpu) begin
            act     = ACT_PASS;
            dest_oh = cpu_dest_oh;
        end else if (!(dmac_is_ours || dmac_is_bcast)) begin
            act     = ACT_DROP;
            dest_oh = '0;
        end else if (!etype_is_ip) begin
            act     = ACT_CPU;
            dest_oh = to_cpu_oh;
        end else if (!ip_csum_ok) begin
            act     = ACT_DROP;
            dest_oh = '0;
        end else if (filt_hit || !ip_ver_ok || ip_has_opts || !ip_ttl_ok
                     || !route_hit || !arp_hit) begin
            act     = ACT_CPU;
            dest_oh = to_cpu_oh;
        end
    end
endmodule

// File: rtl/rtr_fwd_rewrite.sv
module rtr_fwd_rewrite
    import rtr_fwd_pkg::*;
#(
    parameter int NUM_MAC = 4,
    localparam int OH_W = 2 * NUM_MAC
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [2:0]        word_idx,
    input  act_e              act,
    input  logic [OH_W-1:0]   dest_oh,
    input  logic [MAC_W-1:0]  nh_mac,
    input  logic [MAC_W-1:0]  src_mac,
    input  logic [7:0]        ttl,
    input  logic [15:0]       csum,
    output logic [DATA_W-1:0] word_out
);
    always_comb begin
        word_out = word_in;
        if (word_idx == 3'd0) begin
            word_out[DEST_LSB +: OH_W] = dest_oh;
        end else if (act == ACT_FWD) begin
            case (word_idx)
                3'd1: word_out = {nh_mac, src_mac[47:32]};
                3'd2: word_out[63:32] = src_mac[31:0];
                3'd3: word_out[15:8]  = ttl;
                3'd4: word_out[63:48] = csum;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rtr_fwd_ctrl.sv
module rtr_fwd_ctrl
    import rtr_fwd_pkg::*;
#(
    parameter int NUM_MAC    = 4,
    parameter int FIFO_DEPTH = 8,
    localparam int OH_W  = 2 * NUM_MAC,
    localparam int IDX_W = (NUM_MAC > 1) ? $clog2(NUM_MAC) : 1,
    localparam int FW    = DATA_W + CTRL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        in_data,
    input  logic [CTRL_W-1:0]        in_ctrl,
    input  logic                     in_wr,
    output logic                     in_rdy,
    output logic [DATA_W-1:0]        out_data,
    output logic [CTRL_W-1:0]        out_ctrl,
    output logic                     out_wr,
    input  logic                     out_rdy,
    input  logic                     info_vld,
    output logic                     info_rd,
    input  logic                     src_is_cpu,
    input  logic [OH_W-1:0]          cpu_dest_oh,
    input  logic [IDX_W-1:0]         in_mac_port,
    input  logic                     dmac_is_ours,
    input  logic                     dmac_is_bcast,
    input  logic                     etype_is_ip,
    input  logic                     ip_ver_ok,
    input  logic                     ip_csum_ok,
    input  logic                     ip_has_opts,
    input  logic                     ip_ttl_ok,
    input  logic [7:0]               new_ttl,
    input  logic [15:0]              new_csum,
    input  logic                     filt_hit,
    input  logic                     route_hit,
    input  logic [OH_W-1:0]          route_dest_oh,
    input  logic                     arp_hit,
    input  logic [MAC_W-1:0]         arp_mac,
    input  logic [MAC_W*NUM_MAC-1:0] port_macs
);
    typedef struct packed {
        st_e              st;
        act_e             act;
        logic [OH_W-1:0]  dest;
        logic [MAC_W-1:0] nh_mac;
        logic [MAC_W-1:0] src_mac;
        logic [7:0]       ttl;
        logic [15:0]      csum;
        logic [2:0]       idx;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [FW-1:0]     head;
    logic              empty, full, pop;
    logic              head_last;
    act_e              v_act;
    logic [OH_W-1:0]   v_dest;
    logic [IDX_W-1:0]  v_idx;

    rtr_fwd_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (in_wr),
        .din   ({in_data, in_ctrl}),
        .rd    (pop),
        .dout  (head),
        .empty (empty),
        .full  (full)
    );

    rtr_fwd_verdict #(.NUM_MAC(NUM_MAC)) u_verdict (
        .src_is_cpu    (src_is_cpu),
        .cpu_dest_oh   (cpu_dest_oh),
        .in_mac_port   (in_mac_port),
        .dmac_is_ours  (dmac_is_ours),
        .dmac_is_bcast (dmac_is_bcast),
        .etype_is_ip   (etype_is_ip),
        .ip_ver_ok     (ip_ver_ok),
        .ip_csum_ok    (ip_csum_ok),
        .ip_has_opts   (ip_has_opts),
        .ip_ttl_ok     (ip_ttl_ok),
        .filt_hit      (filt_hit),
        .route_hit     (route_hit),
        .route_dest_oh (route_dest_oh),
        .arp_hit       (arp_hit),
        .act           (v_act),
        .dest_oh       (v_dest),
        .mac_idx       (v_idx)
    );

    rtr_fwd_rewrite #(.NUM_MAC(NUM_MAC)) u_rewrite (
        .word_in  (head[FW-1:CTRL_W]),
        .word_idx (c_q.idx),
        .act      (c_q.act),
        .dest_oh  (c_q.dest),
        .nh_mac   (c_q.nh_mac),
        .src_mac  (c_q.src_mac),
        .ttl      (c_q.ttl),
        .csum     (c_q.csum),
        .word_out (out_data)
    );

    assign out_ctrl  = head[CTRL_W-1:0];
    assign head_last = (out_ctrl != CTRL_BODY) && (out_ctrl != CTRL_META);
    assign in_rdy    = !full;

    always_comb begin
        c_d     = c_q;
        info_rd = 1'b0;
        pop     = 1'b0;
        out_wr  = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (info_vld && !empty) begin
                    info_rd     = 1'b1;
                    c_d.act     = v_act;
                    c_d.dest    = v_dest;
                    c_d.nh_mac  = arp_mac;
                    c_d.src_mac = port_macs[int'(v_idx)*MAC_W +: MAC_W];
                    c_d.ttl     = new_ttl;
                    c_d.csum    = new_csum;
                    c_d.idx     = '0;
                    c_d.st      = (v_act == ACT_DROP) ? ST_DROP : ST_SEND;
                end
            end
            ST_SEND: begin
                if (!empty && out_rdy) begin
                    pop    = 1'b1;
                    out_wr = 1'b1;
                    if (c_q.idx != '1) c_d.idx = c_q.idx + 1'b1;
                    if (head_last) c_d.st = ST_IDLE;
                end
            end
            ST_DROP: begin
                if (!empty) begin
                    pop = 1'b1;
                    if (head_last) c_d.st = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    // R11
    info_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        info_rd |=> !info_rd);

    // R9
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && head_last) |=> !out_wr);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_SEND && !empty && !out_rdy) |=>
            ($stable(out_data) && $stable(out_ctrl)));

    // R8
    meta_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_wr && c_q.idx == 3'd0) |-> (out_ctrl == CTRL_META));
endmodule

// File: tb/test_rtr_fwd_ctrl.sv
module test_rtr_fwd_ctrl;
    // default time unit is 1 ps: 5000 ps period = 200 MHz
    localparam int HALF = 2500;
    localparam int NM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic in_wr = 1'b0, in_rdy;
    logic [63:0] out_data;
    logic [7:0]  out_ctrl;
    logic out_wr, out_rdy = 1'b1;
    logic info_vld = 1'b0, info_rd;
    logic src_is_cpu, dmac_is_ours, dmac_is_bcast, etype_is_ip, ip_ver_ok;
    logic ip_csum_ok, ip_has_opts, ip_ttl_ok, filt_hit, route_hit, arp_hit;
    logic [7:0]  cpu_dest_oh, route_dest_oh, new_ttl;
    logic [1:0]  in_mac_port;
    logic [15:0] new_csum;
    logic [47:0] arp_mac;
    logic [191:0] port_macs = {48'h0A00_0000_0033, 48'h0A00_0000_0022,
                               48'h0A00_0000_0011, 48'h0A00_0000_0000};

    int checks = 0, errors = 0;
    logic [63:0] pk_d [32];
    logic [7:0]  pk_c [32];
    logic [63:0] cap_d [64];
    logic [7:0]  cap_c [64];
    int cap_n = 0, rd_cnt = 0;

    rtr_fwd_ctrl #(.NUM_MAC(NM), .FIFO_DEPTH(8)) i_rtr_fwd_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr), .in_rdy(in_rdy),
        .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr), .out_rdy(out_rdy),
        .info_vld(info_vld), .info_rd(info_rd),
        .src_is_cpu(src_is_cpu), .cpu_dest_oh(cpu_dest_oh), .in_mac_port(in_mac_port),
        .dmac_is_ours(dmac_is_ours), .dmac_is_bcast(dmac_is_bcast),
        .etype_is_ip(etype_is_ip), .ip_ver_ok(ip_ver_ok), .ip_csum_ok(ip_csum_ok),
        .ip_has_opts(ip_has_opts), .ip_ttl_ok(ip_ttl_ok), .new_ttl(new_ttl),
        .new_csum(new_csum), .filt_hit(filt_hit), .route_hit(route_hit),
        .route_dest_oh(route_dest_oh), .arp_hit(arp_hit), .arp_mac(arp_mac),
        .port_macs(port_macs)
    );

    always #HALF clk = ~clk;

    // monitor: sample late in the low phase, before the next rising edge
    always @(negedge clk) begin
        #(HALF - 500);
        if (rst_n && out_wr) begin
            if (cap_n < 64) begin
                cap_d[cap_n] = out_data;
                cap_c[cap_n] = out_ctrl;
            end
            cap_n++;
        end
        if (rst_n && info_rd) rd_cnt++;
    end

    task automatic chk(string tag, logic [71:0] got, logic [71:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic defaults();
        src_is_cpu = 0; dmac_is_ours = 1; dmac_is_bcast = 0; etype_is_ip = 1;
        ip_ver_ok = 1; ip_csum_ok = 1; ip_has_opts = 0; ip_ttl_ok = 1;
        filt_hit = 0; route_hit = 1; arp_hit = 1;
        cpu_dest_oh = 8'h04; route_dest_oh = 8'h10; in_mac_port = 2'd1;
        new_ttl = 8'h3F; new_csum = 16'hBEEF; arp_mac = 48'h0200_1111_2222;
    endtask

    task automatic build(int s, int n, int seed);
        for (int k = 0; k < n; k++) begin
            pk_d[s+k] = {16'(seed), 16'(k), 32'hC0DE_5A00 + 32'(k * 17)};
            pk_c[s+k] = 8'h00;
        end
        pk_d[s] = {8'h5C, 8'hAA, 16'(seed), 32'h0000_0040};
        pk_c[s] = 8'hFF;
        pk_c[s+n-1] = 8'h06;
    endtask

    task automatic send(int s, int n);
        for (int k = s; k < s + n; k++) begin
            @(negedge clk);
            while (!in_rdy) begin
                in_wr = 1'b0;
                @(negedge clk);
            end
            in_wr = 1'b1; in_data = pk_d[k]; in_ctrl = pk_c[k];
        end
        @(negedge clk);
        in_wr = 1'b0;
    endtask

    task automatic serve_info();
        info_vld = 1'b1;
        @(negedge clk);
        while (!info_rd) @(negedge clk);
        @(negedge clk);
        info_vld = 1'b0;
    endtask

    task automatic clear_cap();
        cap_n = 0; rd_cnt = 0;
    endtask

    // kind: 0 drop, 1 destination only, 2 full forward edit
    task automatic compare(string tag, int s, int n, int kind, logic [7:0] dest,
                           logic [47:0] smac);
        logic [63:0] e;
        chk({tag, " R11 info_rd pulses"}, 72'(rd_cnt), 72'(1));
        chk({tag, " R9 word count"}, 72'(cap_n), 72'((kind == 0) ? 0 : n));
        if (kind != 0 && cap_n == n) begin
            for (int k = 0; k < n; k++) begin
                e = pk_d[s+k];
                if (k == 0) e[55:48] = dest;
                else if (kind == 2) begin
                    if (k == 1) e = {arp_mac, smac[47:32]};
                    if (k == 2) e[63:32] = smac[31:0];
                    if (k == 3) e[15:8] = new_ttl;
                    if (k == 4) e[63:48] = new_csum;
                end
                chk({tag, " R8 word"}, {cap_d[k], cap_c[k]}, {e, pk_c[s+k]});
            end
        end
    endtask

    task automatic run_one(int n, int seed);
        clear_cap();
        build(0, n, seed);
        fork
            send(0, n);
            serve_info();
        join
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        info_vld = 1'b1;
        @(negedge clk);
        chk("R12 in_rdy", 72'(in_rdy), 72'(1));
        chk("R12 out_wr", 72'(out_wr), 72'(0));
        chk("R12 info_rd", 72'(info_rd), 72'(0));
        info_vld = 1'b0;
    endtask

    task automatic t_from_cpu();
        defaults(); src_is_cpu = 1; dmac_is_ours = 0; etype_is_ip = 0;
        run_one(6, 1);
        compare("R1 from cpu", 0, 6, 1, 8'h04, '0);
    endtask

    task automatic t_not_ours();
        defaults(); dmac_is_ours = 0;
        run_one(6, 2);
        compare("R2 drop", 0, 6, 0, '0, '0);
        chk("R2 fifo drained", 72'(in_rdy), 72'(1));
    endtask

    task automatic t_non_ip();
        defaults(); dmac_is_ours = 0; dmac_is_bcast = 1; etype_is_ip = 0;
        in_mac_port = 2'd2;
        run_one(5, 3);
        compare("R3 non-ip bcast", 0, 5, 1, 8'h20, '0);
    endtask

    task automatic t_bad_csum();
        defaults(); ip_csum_ok = 0; filt_hit = 1;
        run_one(6, 4);
        compare("R4 bad csum", 0, 6, 0, '0, '0);
    endtask

    task automatic t_filter();
        defaults(); filt_hit = 1; ip_ttl_ok = 0;
        run_one(6, 5);
        compare("R5 filter hit", 0, 6, 1, 8'h08, '0);
    endtask

    task automatic t_exceptions();
        for (int v = 0; v < 5; v++) begin
            defaults();
            case (v)
                0: ip_ver_ok = 0;
                1: ip_has_opts = 1;
                2: ip_ttl_ok = 0;
                3: route_hit = 0;
                default: arp_hit = 0;
            endcase
            run_one(6, 10 + v);
            compare($sformatf("R6 exception %0d", v), 0, 6, 1, 8'h08, '0);
        end
    endtask

    task automatic t_forward();
        defaults();
        run_one(7, 20);
        compare("R7 forward port2", 0, 7, 2, 8'h10, 48'h0A00_0000_0022);
        defaults(); route_dest_oh = 8'h01; in_mac_port = 2'd3;
        new_ttl = 8'h07; new_csum = 16'h1234; arp_mac = 48'h0200_ABCD_0001;
        run_one(5, 21);
        compare("R7 forward port0", 0, 5, 2, 8'h01, 48'h0A00_0000_0000);
    endtask

    task automatic t_back_to_back();
        defaults();
        clear_cap();
        build(0, 5, 30);
        build(5, 6, 31);
        fork
            send(0, 11);
            begin
                dmac_is_ours = 0;
                serve_info();
                defaults(); etype_is_ip = 0; in_mac_port = 2'd0;
                serve_info();
            end
        join
        repeat (12) @(negedge clk);
        chk("R9 two decisions", 72'(rd_cnt), 72'(2));
        rd_cnt = 1;
        compare("R9 second packet", 5, 6, 1, 8'h02, '0);
    endtask

    task automatic t_backpressure();
        defaults();
        clear_cap();
        build(0, 12, 40);
        out_rdy = 1'b0;
        fork
            send(0, 12);
            serve_info();
            begin
                repeat (20) @(negedge clk);
                chk("R10 in_rdy low when full", 72'(in_rdy), 72'(0));
                chk("R10 no write while out_rdy low", 72'(cap_n), 72'(0));
                for (int i = 0; i < 30; i++) begin
                    @(negedge clk);
                    out_rdy = (i % 3 != 0);
                end
                out_rdy = 1'b1;
            end
        join
        repeat (12) @(negedge clk);
        compare("R10 stalled forward", 0, 12, 2, 8'h10, 48'h0A00_0000_0022);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        defaults();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_from_cpu();
        t_not_ours();
        t_non_ip();
        t_bad_csum();
        t_filter();
        t_exceptions();
        t_forward();
        t_back_to_back();
        t_backpressure();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule